// File: doc/BRIEF.md
# Configurable Serial Audio Receiver

This block turns a stereo serial audio stream into parallel samples. It watches a bit clock, a left/right clock, a word clock and a serial data line. All four are sampled by a faster system clock that the block runs on. A two-bit format input selects one of four framing styles, and a polarity input selects which bit-clock edge is active. Each received word leaves the block as a 16-bit sample that is aligned to the MSB, together with a one-cycle valid strobe and a channel flag.

Words may be 4 to 16 bits long. A shorter word is placed in the upper bits of the sample and the lower bits are cleared. The sample bits are copied without change, so the gain is unity. Rate conversion, filtering and clock-domain crossing are left to other blocks.

Top module: `serial_audio_rx`

## Requirements
- R1: A synchronous reset (`rst` high) clears `sample_valid` and `sample`. After reset, the first active bit-clock edge only records the levels of `lrck` and `wclk`, so no frame starts on that edge and no word is captured from the half-frame it belongs to.
- R2: With `fmt` = 00, a frame starts on an active edge where `lrck` differs from its level at the previous active edge. The MSB is taken on that same edge and each later bit on each later active edge.
- R3: With `fmt` = 01, the frame starts the same way, but the MSB is taken one active edge after the edge that starts the frame.
- R4: With `fmt` = 10, the MSB is taken 16 active edges after the edge that starts the frame.
- R5: With `fmt` = 11, a frame starts on an active edge where `wclk` is high after being low on the previous active edge. The MSB is taken on that edge and 16 bits are captured. Changes of `lrck` do not start frames in this mode.
- R6: With `bclk_fall` = 0 the active edge is the rising edge of `bclk`. With `bclk_fall` = 1 it is the falling edge.
- R7: In formats 00, 01 and 10 the word length is `wlen`+1 bits, with a minimum of 4 (`wlen` values 0 to 2 give 4 bits). The word appears in the top bits of `sample`, in arrival order, and the low bits are zero.
- R8: Bits that arrive before the MSB position or after the last bit of the word do not change `sample`.
- R9: `sample_left` equals the level of `lrck` at the active edge that started the word (1 = left, 0 = right).
- R10: `sample_valid` is high for exactly one cycle. That cycle follows the system-clock edge that sampled the active edge carrying the word's last bit. `sample` and `sample_left` hold their values until the next word completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rst | input | 1 | Synchronous reset, active high |
| bclk | input | 1 | Serial bit clock |
| lrck | input | 1 | Left/right clock, high = left |
| wclk | input | 1 | Word clock; its rising edge marks a word in format 11 |
| sdata | input | 1 | Serial data, MSB first |
| fmt | input | 2 | Framing: 00 left, 01 one-bit delay, 10 right (16-bit delay), 11 word clock |
| bclk_fall | input | 1 | 1 selects the falling bit-clock edge as active |
| wlen | input | 4 | Word length minus one for formats 00 to 10 |
| sample | output | 16 | Received word, MSB aligned |
| sample_valid | output | 1 | One-cycle strobe for a completed word |
| sample_left | output | 1 | Channel of the completed word |

## Verification
If the edge counter or the frame-start detection goes wrong, the captured word is shifted by one or more bit positions. That error shows on `sample` at the very first strobe of the frame concerned, and the strobe itself arrives in a different cycle from the one the reference predicts. If the shift register is corrupted, the data is wrong at the end of that word. If the channel flag or the holding register is wrong, the fault shows either on the next strobe or in the cycle after the strobe, because the bench compares `sample` and `sample_left` on every clock. Bits outside each word are filled with random values, so a capture window that is too wide changes the output within one word.

// File: rtl/serial_audio_rx.sv
`timescale 1ns/1ps
module serial_audio_rx #(
  parameter int W        = 16,
  parameter int RJ_DELAY = 16,
  parameter int CW       = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bclk,
  input  logic         lrck,
  input  logic         wclk,
  input  logic         sdata,
  input  logic [1:0]   fmt,
  input  logic         bclk_fall,
  input  logic [3:0]   wlen,
  output logic [W-1:0] sample,
  output logic         sample_valid,
  output logic         sample_left
);
  localparam int CMAX = (1 << CW) - 1;

  logic          bclk_d, seen, lr_prev, wc_prev, tag;
  logic [CW-1:0] cnt, idx, off, len;
  logic [W-1:0]  sh;

  wire lr_mode = (fmt != 2'b11);
  wire act     = (bclk ^ bclk_d) & (bclk ^ bclk_fall);
  wire start   = seen & (lr_mode ? (lrck ^ lr_prev) : (wclk & ~wc_prev));

  always_comb begin
    case (fmt)
      2'b01:   off = CW'(1);
      2'b10:   off = CW'(RJ_DELAY);
      default: off = '0;
    endcase
    if (!lr_mode)        len = CW'(W);
    else if (wlen < 4'd3) len = CW'(4);
    else                 len = CW'(wlen) + CW'(1);
  end

  assign idx = start ? '0 : ((cnt == CW'(CMAX)) ? cnt : cnt + CW'(1));

  wire          take  = (idx >= off) && (idx < off + len);
  wire          last  = (idx == off + len - CW'(1));
  wire [W-1:0]  base  = start ? '0 : sh;
  wire [W-1:0]  shin  = {base[W-2:0], sdata};
  wire          tag_n = start ? lrck : tag;

  always_ff @(posedge clk) bclk_d <= bclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen         <= 1'b0;
      lr_prev      <= 1'b0;
      wc_prev      <= 1'b0;
      tag          <= 1'b0;
      cnt          <= CW'(CMAX);
      sh           <= '0;
      sample       <= '0;
      sample_valid <= 1'b0;
      sample_left  <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      if (act) begin
        seen    <= 1'b1;
        lr_prev <= lrck;
        wc_prev <= wclk;
        tag     <= tag_n;
        cnt     <= idx;
        if (take)       sh <= shin;
        else if (start) sh <= '0;
        if (take && last) begin
          sample       <= shin << (CW'(W) - len);
          sample_valid <= 1'b1;
          sample_left  <= tag_n;
        end
      end
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!sample_valid && sample == '0));

  p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!sample_valid && !$past(rst)) |-> ($stable(sample) && $stable(sample_left)));

  p_low_zero_r7: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> (W'(sample << len) == '0));

  p_edge_r6: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> (($past(bclk) != $past(bclk_fall)) && ($past(bclk, 2) == $past(bclk_fall))));
endmodule

// File: tb/sim_serial_audio_rx.sv
`timescale 1ns/1ps
module sim_serial_audio_rx;
  logic clk = 1'b0, rst = 1'b1;
  logic bclk = 1'b0, lrck = 1'b0, wclk = 1'b0, sdata = 1'b0;
  logic [1:0] fmt = 2'b00;
  logic bclk_fall = 1'b0;
  logic [3:0] wlen = 4'd15;
  logic [15:0] sample;
  logic sample_valid, sample_left;

  serial_audio_rx u0 (.clk(clk), .rst(rst), .bclk(bclk), .lrck(lrck), .wclk(wclk),
    .sdata(sdata), .fmt(fmt), .bclk_fall(bclk_fall), .wlen(wlen),
    .sample(sample), .sample_valid(sample_valid), .sample_left(sample_left));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, woff = 0;
  bit mon_en = 1'b0, done = 1'b0;
  string phase = "R1";
  int q_t[$];
  logic [15:0] q_d[$];
  bit q_l[$];
  logic [15:0] hold_d = '0;
  bit hold_l = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mon_en && !rst) begin
      if (q_t.size() > 0 && q_t[0] < cyc) begin
        checks++; errors++;
        $display("FAIL %s missing strobe: actual valid=0 expected valid=1 at cycle %0d", phase, q_t[0]);
        void'(q_t.pop_front()); void'(q_d.pop_front()); void'(q_l.pop_front());
      end
      if (sample_valid) begin
        checks++;
        if (q_t.size() == 0 || q_t[0] != cyc) begin
          errors++;
          $display("FAIL %s R10 unexpected strobe: actual valid=1 expected valid=0 (cycle %0d)", phase, cyc);
        end else begin
          if (sample !== q_d[0]) begin
            errors++;
            $display("FAIL %s data: actual %h expected %h", phase, sample, q_d[0]);
          end
          checks++;
          if (sample_left !== q_l[0]) begin
            errors++;
            $display("FAIL R9 channel: actual %0b expected %0b", sample_left, q_l[0]);
          end
          hold_d = q_d[0]; hold_l = q_l[0];
          void'(q_t.pop_front()); void'(q_d.pop_front()); void'(q_l.pop_front());
        end
      end else begin
        checks++;
        if (sample !== hold_d || sample_left !== hold_l) begin
          errors++;
          $display("FAIL R10 hold: actual %h/%0b expected %h/%0b", sample, sample_left, hold_d, hold_l);
        end
      end
    end
  end

  task automatic drive_bit(bit lr, bit wc, bit sd, bit push, logic [15:0] ed);
    @(negedge clk);
    bclk = bclk_fall; lrck = lr; wclk = wc; sdata = sd;
    @(negedge clk);
    @(negedge clk);
    bclk = ~bclk_fall;
    if (push) begin q_t.push_back(cyc + 1); q_d.push_back(ed); q_l.push_back(lr); end
    @(negedge clk);
  endtask

  task automatic send_half(bit lr, logic [15:0] d, bit expect_it);
    int off, len;
    logic [15:0] ed;
    case (fmt)
      2'b00: off = 0;
      2'b01: off = 1;
      2'b10: off = 16;
      default: off = woff;
    endcase
    len = (fmt == 2'b11) ? 16 : ((wlen < 3) ? 4 : int'(wlen) + 1);
    ed = d & (16'hFFFF << (16 - len));
    for (int i = 0; i < 32; i++) begin
      bit inw, sd, wc;
      inw = (i >= off) && (i < off + len);
      sd  = inw ? d[15 - (i - off)] : 1'($urandom);
      wc  = expect_it && (fmt == 2'b11) && (i == off);
      drive_bit(lr, wc, sd, expect_it && inw && (i == off + len - 1), ed);
    end
  endtask

  task automatic start_phase(string tag, logic [1:0] f, bit pol, logic [3:0] wl);
    @(negedge clk);
    mon_en = 1'b0; rst = 1'b1;
    fmt = f; bclk_fall = pol; wlen = wl; bclk = pol; lrck = 1'b0; wclk = 1'b0;
    q_t.delete(); q_d.delete(); q_l.delete();
    repeat (3) @(negedge clk);
    checks++;
    if (sample_valid !== 1'b0 || sample !== 16'h0) begin
      errors++;
      $display("FAIL R1 reset: actual %0b/%h expected 0/0000", sample_valid, sample);
    end
    rst = 1'b0; hold_d = '0; hold_l = 1'b0; mon_en = 1'b1;
    phase = "R1";
    send_half(1'b0, 16'hFFFF, 1'b0);
    phase = tag;
  endtask

  task automatic run_pairs(int n);
    for (int k = 0; k < n; k++) begin
      logic [15:0] a, b;
      a = (k == 0) ? 16'h8001 : ((k == 1) ? 16'hFFFF : 16'($urandom));
      b = (k == 0) ? 16'h0000 : 16'($urandom);
      send_half(1'b1, a, 1'b1);
      send_half(1'b0, b, 1'b1);
    end
  endtask

  initial begin
    start_phase("R2", 2'b00, 1'b0, 4'd15); run_pairs(4);
    start_phase("R3", 2'b01, 1'b0, 4'd15); run_pairs(4);
    start_phase("R4", 2'b10, 1'b0, 4'd15); run_pairs(4);
    woff = 0; start_phase("R5", 2'b11, 1'b0, 4'd15); run_pairs(3);
    woff = 5; start_phase("R5", 2'b11, 1'b0, 4'd2);  run_pairs(3);
    start_phase("R6", 2'b00, 1'b1, 4'd15); run_pairs(3);
    start_phase("R6", 2'b01, 1'b1, 4'd15); run_pairs(3);
    start_phase("R7", 2'b00, 1'b0, 4'd7);  run_pairs(3);
    start_phase("R7", 2'b10, 1'b0, 4'd3);  run_pairs(3);
    start_phase("R7", 2'b01, 1'b0, 4'd0);  run_pairs(3);
    start_phase("R8", 2'b00, 1'b0, 4'd11); run_pairs(3);
    start_phase("R8", 2'b10, 1'b1, 4'd5);  run_pairs(3);
    repeat (4) @(negedge clk);
    checks++;
    if (q_t.size() != 0) begin
      errors++;
      $display("FAIL R10 pending strobes: actual %0d expected 0", q_t.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule